// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the two modem-handshake registers of a 16550-style serial port. The control register drives the four handshake outputs (data terminal ready, request to send, and two general-purpose outputs) and a loopback-enable bit. The status register reports the levels of the four handshake inputs: clear to send, data set ready, ring indicator and carrier detect. Beside each level it keeps a sticky change flag.

The inputs are brought into the clock domain through a synchronizer. Each synchronized level is then compared with the level the register held before. Any change sets the matching change flag, except the ring indicator, whose flag reacts only to a falling line. A read of the status register clears the change flags. A single "any change pending" output goes to the interrupt logic.

In loopback the control bits are folded back onto the status levels and the real input pins are ignored. The four handshake outputs are forced low while loopback is on. Register access is one port: a select bit chooses control (0) or status (1), and read data is valid in the same cycle as the access.

Top module: `modem_ctl_stat`

## Requirements
- R1: A control write stores only data bits 4..0, laid out as DTR=bit0, RTS=bit1, OUT1=bit2, OUT2=bit3, LOOP=bit4. A control read returns those bits with bits 7..5 reading 0.
- R2: Outside loopback, dtr_o, rts_o, out1_o and out2_o follow control bits 0, 1, 2 and 3. loop_o follows control bit 4.
- R3: After reset, control reads 0x08 (only out2_o high) and status reads 0xB0 (carrier, data-set-ready and clear-to-send high, no change flags). delta_pend_o is 0.
- R4: The status levels sit at bit4=CTS, bit5=DSR, bit6=RI and bit7=DCD. Their change flags sit at bit0, bit1, bit2 and bit3. A change of CTS, DSR or DCD in either direction sets its flag, and the flag stays set until a status read.
- R5: The RI change flag (bit 2) is set when RI falls from 1 to 0 and never when it rises.
- R6: A status read outside loopback returns the current value and clears bits 3..0 at the access edge. Bits 7..4 are left unchanged.
- R7: A line change that is recorded on the same edge as a clearing status read stays set after that read.
- R8: In loopback a status read returns {OUT2, OUT1, DTR, RTS} in bits 7..4 and 0 in bits 3..0. Pin activity records no change, and the read does not clear flags that were already set.
- R9: While loopback is on, dtr_o, rts_o, out1_o and out2_o are 0.
- R10: Writes with sel=1 (status) change neither register.
- R11: With the default two synchronizer stages, a pin change shows in the status register on the third rising clock edge after it is applied.
- R12: delta_pend_o is 1 exactly when at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (status read clears change flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, same cycle |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| ri_i | input | 1 | Ring-indicator input, asynchronous |
| dcd_i | input | 1 | Carrier-detect input, asynchronous |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| loop_o | output | 1 | Loopback enabled |
| delta_pend_o | output | 1 | At least one change flag set |

## Verification
A wrong stored line level appears at the ports as a false change flag. That flag shows on delta_pend_o three edges after the input moved, and it is still visible at the next status read. A change flag dropped or cleared at the wrong time shows on delta_pend_o within one edge of the cause. A wrong loopback mapping or output gating appears on the very first status read, or at once on the handshake pins. The bench therefore samples each of these at a fixed cycle after its stimulus.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
   localparam int LINE_W = 4;
   localparam int CTRL_W = 5;

   // line nibble order (matches status bits 7..4)
   localparam int L_CTS = 0;
   localparam int L_DSR = 1;
   localparam int L_RI  = 2;
   localparam int L_DCD = 3;

   // control field positions
   localparam int C_DTR  = 0;
   localparam int C_RTS  = 1;
   localparam int C_OUT1 = 2;
   localparam int C_OUT2 = 3;
   localparam int C_LOOP = 4;

   function automatic logic [LINE_W-1:0] fold_back(input logic [CTRL_W-1:0] c);
      logic [LINE_W-1:0] n;
      n[L_DCD] = c[C_OUT2];
      n[L_RI]  = c[C_OUT1];
      n[L_DSR] = c[C_DTR];
      n[L_CTS] = c[C_RTS];
      return n;
   endfunction
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("mcs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mcs_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= RST_VAL;
         else if (s == 0) stg_q[s] <= d_i;
         else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta #(
   parameter int               W       = 4,
   parameter int               FALL_IX = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_i,
   input  logic         hold_i,
   input  logic         clr_i,
   output logic [W-1:0] state_o,
   output logic [W-1:0] delta_o
);
   if (FALL_IX >= W) begin : g_bad_ix
      $error("mcs_delta: FALL_IX out of range");
   end

   logic [W-1:0] state_q, delta_q, nxt_line, chg;

   assign nxt_line = hold_i ? state_q : line_i;

   for (genvar i = 0; i < W; i++) begin : g_edge
      if (i == FALL_IX) begin : g_fall_only
         assign chg[i] = state_q[i] & ~nxt_line[i];
      end else begin : g_any
         assign chg[i] = state_q[i] ^ nxt_line[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RST_VAL;
         delta_q <= '0;
      end else begin
         state_q <= nxt_line;
         delta_q <= (clr_i ? '0 : delta_q) | chg;
      end
   end

   assign state_o = state_q;
   assign delta_o = delta_q;
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
   import mcs_pkg::*;
#(
   parameter logic [CTRL_W-1:0] RST_VAL = 5'b01000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              out1_o,
   output logic              out2_o,
   output logic              loop_o
);
   logic [CTRL_W-1:0] ctrl_q;
   logic              gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= RST_VAL;
      else if (we_i) ctrl_q <= wdata_i;
   end

   assign gate   = ~ctrl_q[C_LOOP];
   assign dtr_o  = ctrl_q[C_DTR]  & gate;
   assign rts_o  = ctrl_q[C_RTS]  & gate;
   assign out1_o = ctrl_q[C_OUT1] & gate;
   assign out2_o = ctrl_q[C_OUT2] & gate;
   assign loop_o = ctrl_q[C_LOOP];
   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
   import mcs_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [LINE_W-1:0] LINE_RST   = 4'b1011,
   parameter logic [CTRL_W-1:0] CTRL_RST   = 5'b01000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              cts_i,
   input  logic              dsr_i,
   input  logic              ri_i,
   input  logic              dcd_i,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              out1_o,
   output logic              out2_o,
   output logic              loop_o,
   output logic              delta_pend_o
);
   localparam int PAD_W = DATA_W - CTRL_W;

   if (DATA_W != 2*LINE_W) begin : g_bad_dw
      $error("modem_ctl_stat: DATA_W must hold level and flag nibbles");
   end

   logic [CTRL_W-1:0] ctrl;
   logic [LINE_W-1:0] raw_lines, sync_lines, lvl, dlt;
   logic              stat_rd_clr;
   logic              unused_hi;

   assign unused_hi = ^wdata[DATA_W-1:CTRL_W];

   assign raw_lines[L_CTS] = cts_i;
   assign raw_lines[L_DSR] = dsr_i;
   assign raw_lines[L_RI]  = ri_i;
   assign raw_lines[L_DCD] = dcd_i;

   mcs_ctrl #(.RST_VAL(CTRL_RST)) u_ctrl (
      .clk, .rst_n,
      .we_i    (wr_en & ~sel),
      .wdata_i (wdata[CTRL_W-1:0]),
      .ctrl_o  (ctrl),
      .dtr_o, .rts_o, .out1_o, .out2_o, .loop_o
   );

   mcs_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
      .clk, .rst_n, .d_i(raw_lines), .q_o(sync_lines)
   );

   assign stat_rd_clr = rd_en & sel & ~ctrl[C_LOOP];

   mcs_delta #(.W(LINE_W), .FALL_IX(L_RI), .RST_VAL(LINE_RST)) u_delta (
      .clk, .rst_n,
      .line_i  (sync_lines),
      .hold_i  (ctrl[C_LOOP]),
      .clr_i   (stat_rd_clr),
      .state_o (lvl),
      .delta_o (dlt)
   );

   always_comb begin
      if (!sel)               rdata = {{PAD_W{1'b0}}, ctrl};
      else if (ctrl[C_LOOP])  rdata = {fold_back(ctrl), {LINE_W{1'b0}}};
      else                    rdata = {lvl, dlt};
   end

   assign delta_pend_o = |dlt;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sel,
   input logic       wr_en,
   input logic       rd_en,
   input logic [7:0] rdata,
   input logic       dtr_o,
   input logic       rts_o,
   input logic       out1_o,
   input logic       out2_o,
   input logic       loop_o,
   input logic       delta_pend_o
);
   p_ctrl_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> rdata[7:5] == 3'b000);

   p_pins_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_o |-> !(dtr_o || rts_o || out1_o || out2_o));

   p_pend_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (delta_pend_o && !(rd_en && sel && !loop_o)) |=> delta_pend_o);

   p_loop_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      loop_o |=> $stable(delta_pend_o));

   p_status_wr_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel) |=> $stable({loop_o, dtr_o, rts_o, out1_o, out2_o}));

   p_loop_flags_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && loop_o) |-> rdata[3:0] == 4'h0);
endmodule

bind modem_ctl_stat mcs_checker u_chk (.*);

// File: tb/sim_modem_ctl_stat.sv
`timescale 1ns/1ps
module sim_modem_ctl_stat;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
   logic       dtr_o, rts_o, out1_o, out2_o, loop_o, delta_pend_o;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   modem_ctl_stat u0 (.*);

   // pins = {dcd, ri, dsr, cts}, expected status read value
   localparam logic [15:0] VEC [8] = '{
      {8'h0B, 8'hB0},   // idle, no change
      {8'h0A, 8'hA1},   // CTS falls
      {8'h0E, 8'hE0},   // RI rises: no flag
      {8'h0A, 8'hA4},   // RI falls: flag bit2
      {8'h00, 8'h0A},   // DCD and DSR fall
      {8'h0F, 8'hFB},   // all rise, RI gives no flag
      {8'h0B, 8'hB4},   // RI falls only
      {8'h0B, 8'hB0}    // settled
   };

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic set_pins(input logic [3:0] p);
      @(negedge clk);
      {dcd_i, ri_i, dsr_i, cts_i} = p;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic s, input logic [7:0] d);
      @(negedge clk);
      sel = s; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic s, output logic [7:0] v);
      @(negedge clk);
      sel = s; rd_en = 1'b1;
      #0.5 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);

      // R3 reset state
      rd(1'b0, v); chk("R3 ctrl", v, 8'h08);
      rd(1'b1, v); chk("R3 status", v, 8'hB0);
      chk("R3 pins", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
      chk("R3 pend", {7'b0, delta_pend_o}, 8'h00);

      // R4 R5 R6 table walk
      for (int k = 0; k < 8; k++) begin
         set_pins(VEC[k][11:8]);
         wait_cyc(4);
         chk("R12 pend", {7'b0, delta_pend_o}, {7'b0, |VEC[k][3:0]});
         rd(1'b1, v);
         chk("R4 R5 status", v, VEC[k][7:0]);
         chk("R6 pend cleared", {7'b0, delta_pend_o}, 8'h00);
         rd(1'b1, v);
         chk("R6 level kept", v, {VEC[k][7:4], 4'h0});
      end

      // R4 sticky: CTS falls and rises before a read
      set_pins(4'hA); wait_cyc(4);
      set_pins(4'hB); wait_cyc(4);
      rd(1'b1, v); chk("R4 sticky", v, 8'hB1);

      // R11 latency
      set_pins(4'hA);
      @(negedge clk); chk("R11 edge1", {7'b0, delta_pend_o}, 8'h00);
      @(negedge clk); chk("R11 edge2", {7'b0, delta_pend_o}, 8'h00);
      @(negedge clk); chk("R11 edge3", {7'b0, delta_pend_o}, 8'h01);
      rd(1'b1, v); chk("R11 status", v, 8'hA1);

      // R7 change recorded on the edge of a clearing read
      set_pins(4'hB);
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      sel = 1'b1; rd_en = 1'b1;
      #0.5 v = rdata;
      chk("R7 before", v, 8'hA0);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R7 kept pend", {7'b0, delta_pend_o}, 8'h01);
      rd(1'b1, v); chk("R7 kept status", v, 8'hB1);

      // R1 R2 control register
      wr(1'b0, 8'hEF);
      rd(1'b0, v); chk("R1 masked", v, 8'h0F);
      chk("R2 pins all", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h0F);
      wr(1'b0, 8'h05);
      chk("R2 pins dtr out1", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h05);
      wr(1'b0, 8'h0A);
      chk("R2 pins rts out2", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h0A);

      // R10 writes to status ignored
      wr(1'b1, 8'h55);
      rd(1'b0, v); chk("R10 ctrl", v, 8'h0A);
      rd(1'b1, v); chk("R10 status", v, 8'hB0);

      // R8 R9 loopback
      set_pins(4'hA); wait_cyc(4);
      chk("R8 pre pend", {7'b0, delta_pend_o}, 8'h01);
      wr(1'b0, 8'h1B);
      chk("R9 pins off", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h10);
      rd(1'b1, v); chk("R8 map b", v, 8'hB0);
      chk("R8 no clear", {7'b0, delta_pend_o}, 8'h01);
      set_pins(4'h5); wait_cyc(4);
      rd(1'b1, v); chk("R8 pins ignored", v, 8'hB0);
      wr(1'b0, 8'h14);
      rd(1'b1, v); chk("R8 map out1", v, 8'h40);
      chk("R9 pins off2", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h10);
      set_pins(4'hA); wait_cyc(4);
      wr(1'b0, 8'h08); wait_cyc(4);
      rd(1'b1, v); chk("R8 flags kept", v, 8'hA1);
      rd(1'b1, v); chk("R6 after loop", v, 8'hA0);

      finish_run();
   end
endmodule